// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block gives a processor byte-wide access to a shared table of 64 colours of 16 bits each. The table has two halves. Entries 0 to 31 hold the background colours and entries 32 to 63 hold the object colours, which makes eight palettes of four colours per half. Each half is reached through its own pair of registers. The pointer register holds a byte pointer and an auto-advance flag. The data register reads or writes the byte that the pointer selects.

Because the pointer counts bytes, one 16-bit colour takes two data accesses: the low byte at an even pointer and the high byte at an odd one. With the auto-advance flag set, software can stream a whole palette through one data register. Each half keeps a readback byte that is refreshed whenever its pointer moves, so a data read always returns the byte under the pointer.

A combinational lookup port returns any full 16-bit colour. It stands in for the renderer's access and is used for checking.

Top module: `pal_index_port`

## Requirements
- R1: `regSel` picks the register: 0 is the background pointer, 1 is background data, 2 is the object pointer and 3 is object data. A write takes effect at the rising clock edge on which `wrEn` is high.
- R2: A pointer write loads bits 5:0 as the byte pointer and bit 7 as the auto-advance flag. Bit 6 is ignored. A pointer read returns {flag, 1, pointer}, so bit 6 always reads as 1.
- R3: A byte pointer p addresses entry p>>1 for the background half and entry 32+(p>>1) for the object half. p[0]=0 selects bits 7:0 of that entry and p[0]=1 selects bits 15:8.
- R4: A data write stores the byte into the selected half of the selected entry and leaves the other byte of that entry unchanged.
- R5: When the flag is set, each data write advances that half's pointer by one, wrapping from 63 to 0. When the flag is clear, the pointer does not move.
- R6: After a pointer write, the very next data read of that half returns the byte at the new pointer.
- R7: A data read returns the current byte under the pointer, including a byte written a moment earlier and the byte reached after an auto-advance.
- R8: `rdData` is combinational while `rdEn` is high and is 0 while `rdEn` is low. Reads have no side effect.
- R9: `lookColour` returns the full entry at `lookAddr` combinationally. It shows a data write from the cycle after that write's clock edge.
- R10: After reset every entry is 0, both pointers are 0 and both flags are clear, so a pointer read returns 0x40.
- R11: A write to one half changes neither the pointer, the flag nor the readback byte of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select (see R1) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read byte, combinational |
| lookAddr | input | 6 | Entry address for the lookup port |
| lookColour | output | 16 | Full 16-bit colour at `lookAddr` |

## Verification
Every write lands at one rising edge. Its effect on pointers, flags, readback bytes and the lookup port is due in the same cycle, just after that edge. Reads and lookups are combinational, so their results are due with no delay at all. The bench therefore drives each write at a falling edge and lowers the strobe at the next falling edge, when the write's edge has already passed. It raises `rdEn` at a falling edge and samples one nanosecond later, well away from any rising edge. A running model in the bench, updated once per write, gives the expected value of every sample.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Byte pointer width; the table holds 2**PAL_IDX_W colours.
  localparam int PAL_IDX_W = 6;

  // Register select codes; bit 1 picks the half, bit 0 picks data versus pointer.
  localparam logic [1:0] SEL_BG_IDX  = 2'd0;
  localparam logic [1:0] SEL_BG_DATA = 2'd1;
  localparam logic [1:0] SEL_OB_IDX  = 2'd2;
  localparam logic [1:0] SEL_OB_DATA = 2'd3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 idxWr;   // pointer register written this cycle
    logic                 dataWr;  // data register written this cycle
    logic                 setSel;  // 0 background, 1 object
    logic [PAL_IDX_W-1:0] curIdx;  // pointer of the selected half before the edge
    logic [PAL_IDX_W-1:0] newIdx;  // pointer of the selected half after the edge
  } palStrobes_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [1:0]            regSel,
  input  logic [DATA_W-1:0]     wrData,
  output palStrobes_t           strb,
  output logic [1:0][IDX_W-1:0] idxReg,
  output logic [1:0]            incFlag
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic isData;
  logic setSel;

  always_comb begin
    setSel      = regSel[1];
    isData      = regSel[0];
    strb.setSel = setSel;
    strb.idxWr  = wrEn & ~isData;
    strb.dataWr = wrEn & isData;
    strb.curIdx = idxReg[setSel];
    if (strb.idxWr)
      strb.newIdx = wrData[IDX_W-1:0];
    else if (strb.dataWr && incFlag[setSel])
      strb.newIdx = strb.curIdx + 1'b1;
    else
      strb.newIdx = strb.curIdx;
  end

  for (genvar s = 0; s < 2; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idxReg[s]  <= '0;
        incFlag[s] <= 1'b0;
      end else if (wrEn && (setSel == s[0])) begin
        idxReg[s] <= strb.newIdx;
        if (strb.idxWr) incFlag[s] <= wrData[FLAG_BIT];
      end
    end
  end
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  palStrobes_t           strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [1:0]            regSel,
  input  logic                  rdEn,
  input  logic [1:0][IDX_W-1:0] idxReg,
  input  logic [1:0]            incFlag,
  input  logic [IDX_W-1:0]      lookAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [2*DATA_W-1:0]   lookColour
);
  localparam int COL_W       = 2 * DATA_W;
  localparam int NUM_ENTRIES = 2 ** IDX_W;

  logic [COL_W-1:0]  colourMem [NUM_ENTRIES];
  logic [DATA_W-1:0] rbByte [2];

  logic [IDX_W-1:0]  wrEntry, nextEntry;
  logic [COL_W-1:0]  mergedWord, nextWord;
  logic [DATA_W-1:0] nextByte;

  always_comb begin
    // Entry address: the half bit on top, the pointer without its byte bit below.
    wrEntry    = {strb.setSel, strb.curIdx[IDX_W-1:1]};
    nextEntry  = {strb.setSel, strb.newIdx[IDX_W-1:1]};
    mergedWord = colourMem[wrEntry];
    if (strb.curIdx[0]) mergedWord[COL_W-1:DATA_W] = wrData;
    else                mergedWord[DATA_W-1:0]     = wrData;
    // Forward the word being written when the pointer stays on it.
    if (strb.dataWr && (nextEntry == wrEntry)) nextWord = mergedWord;
    else                                       nextWord = colourMem[nextEntry];
    nextByte = strb.newIdx[0] ? nextWord[COL_W-1:DATA_W] : nextWord[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) colourMem[e] <= '0;
    end else if (strb.dataWr) begin
      colourMem[wrEntry] <= mergedWord;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_rb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rbByte[s] <= '0;
      else if ((strb.idxWr || strb.dataWr) && (strb.setSel == s[0]))
        rbByte[s] <= nextByte;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (regSel[0])
        rdData = rbByte[regSel[1]];
      else
        rdData = {incFlag[regSel[1]], 1'b1, idxReg[regSel[1]]};
    end
    lookColour = colourMem[lookAddr];
  end
endmodule

// File: rtl/pal_index_port.sv
module pal_index_port
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            regSel,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [DATA_W-1:0]     rdData,
  input  logic [IDX_W-1:0]      lookAddr,
  output logic [2*DATA_W-1:0]   lookColour
);
  palStrobes_t           strb;
  logic [1:0][IDX_W-1:0] idxReg;
  logic [1:0]            incFlag;

  pal_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .strb(strb), .idxReg(idxReg), .incFlag(incFlag)
  );

  pal_datapath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData), .regSel(regSel),
    .rdEn(rdEn), .idxReg(idxReg), .incFlag(incFlag), .lookAddr(lookAddr),
    .rdData(rdData), .lookColour(lookColour)
  );
endmodule

// File: rtl/pal_index_port_chk.sv
module pal_index_port_chk #(
  parameter int IDX_W  = pal_pkg::PAL_IDX_W,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            regSel,
  input logic                  wrEn,
  input logic [DATA_W-1:0]     wrData,
  input logic                  rdEn,
  input logic [DATA_W-1:0]     rdData,
  input logic [1:0][IDX_W-1:0] idxReg,
  input logic [1:0]            incFlag
);
  // R2: a pointer read always shows bit 6 set
  a_r2_ptr_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !regSel[0]) |-> rdData[6]);

  // R8: the read bus is quiet without a read strobe
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> (rdData == '0));

  for (genvar s = 0; s < 2; s++) begin : g_s
    // R2: a pointer write loads the pointer and the flag
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && regSel == {s[0], 1'b0}) |=>
        (idxReg[s] == $past(wrData[IDX_W-1:0])) && (incFlag[s] == $past(wrData[DATA_W-1])));

    // R5: a data write with the flag set advances the pointer by one, modulo 64
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && regSel == {s[0], 1'b1} && incFlag[s]) |=>
        (idxReg[s] == IDX_W'($past(idxReg[s]) + 1'b1)));

    // R5: a data write with the flag clear keeps the pointer
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && regSel == {s[0], 1'b1} && !incFlag[s]) |=> $stable(idxReg[s]));

    // R11: a write to the other half leaves this half alone
    a_r11_other_half: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && regSel[1] != s[0]) |=> ($stable(idxReg[s]) && $stable(incFlag[s])));
  end
endmodule

bind pal_index_port pal_index_port_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/pal_index_port_tb_top.sv
module pal_index_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [5:0]  lookAddr = '0;
  logic [15:0] lookColour;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Model state of the bench
  logic [15:0] mMem [64];
  logic [5:0]  mIdx [2];
  logic        mInc [2];

  always #2 clk = ~clk;

  pal_index_port dut_i (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .lookAddr(lookAddr), .lookColour(lookColour)
  );

  function automatic logic [5:0] entryOf(int s, logic [5:0] p);
    return {s[0], p[5:1]};
  endfunction

  function automatic logic [7:0] byteAt(int s);
    logic [15:0] w;
    w = mMem[entryOf(s, mIdx[s])];
    return mIdx[s][0] ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [7:0] expRead(logic [1:0] sel);
    int s;
    s = sel[1];
    if (sel[0]) return byteAt(s);
    return {mInc[s], 1'b1, mIdx[s]};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [1:0] sel, logic [7:0] val);
    int s;
    logic [5:0] e;
    @(negedge clk);
    regSel = sel; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    s = sel[1];
    if (!sel[0]) begin
      mIdx[s] = val[5:0];
      mInc[s] = val[7];
    end else begin
      e = entryOf(s, mIdx[s]);
      if (mIdx[s][0]) mMem[e][15:8] = val;
      else            mMem[e][7:0]  = val;
      if (mInc[s]) mIdx[s] = mIdx[s] + 6'd1;
    end
  endtask

  task automatic doRead(logic [1:0] sel, string req);
    regSel = sel; rdEn = 1'b1;
    #1;
    check(req, {8'h00, rdData}, {8'h00, expRead(sel)});
    rdEn = 1'b0;
    #1;
  endtask

  task automatic doLook(logic [5:0] a, string req);
    lookAddr = a;
    #1;
    check(req, lookColour, mMem[a]);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int seedv;
    seedv = $urandom(32'h5eed_1234);
    for (int e = 0; e < 64; e++) mMem[e] = '0;
    for (int s = 0; s < 2; s++) begin mIdx[s] = '0; mInc[s] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    rdEn = 1'b1; regSel = 2'd0; #1; check("R10", {8'h00, rdData}, 16'h0040); rdEn = 1'b0;
    doRead(2'd2, "R10");
    doRead(2'd1, "R10");
    doLook(6'd40, "R10");
    // R8: no read strobe gives zero
    regSel = 2'd0; #1; check("R8", {8'h00, rdData}, 16'h0000);

    // R2 / R3 / R4: advancing pointer at 5 means entry 2, high byte
    doWrite(2'd0, 8'hC5);
    doRead(2'd0, "R2");
    rdEn = 1'b1; regSel = 2'd0; #1; check("R2", {8'h00, rdData}, 16'h00C5); rdEn = 1'b0;
    doWrite(2'd1, 8'hAB);
    doLook(6'd2, "R4");
    check("R3", lookColour, 16'hAB00);
    doRead(2'd0, "R5");           // pointer advanced to 6
    doWrite(2'd1, 8'hCD);         // entry 3 low byte
    doLook(6'd3, "R3");
    check("R4", lookColour, 16'h00CD);
    doWrite(2'd0, 8'h87);         // pointer 7: entry 3 high, low kept
    doWrite(2'd1, 8'h5A);
    doLook(6'd3, "R4");
    check("R4", lookColour, 16'h5ACD);

    // R5: wrap from 63 to 0
    doWrite(2'd0, 8'hBF);
    doWrite(2'd1, 8'h11);
    doRead(2'd0, "R5");
    rdEn = 1'b1; regSel = 2'd0; #1; check("R5", {8'h00, rdData}, 16'h00C0); rdEn = 1'b0;
    doLook(6'd31, "R3");

    // Object half at offset 32, flag clear keeps the pointer
    doWrite(2'd2, 8'h01);
    doWrite(2'd3, 8'h77);
    doLook(6'd32, "R3");
    check("R3", lookColour, 16'h7700);
    doRead(2'd2, "R5");
    doRead(2'd3, "R7");           // reads back the byte just written
    doRead(2'd0, "R11");          // background pointer untouched

    // R6: a pointer write refreshes the readback byte
    doWrite(2'd0, 8'h05);
    doRead(2'd1, "R6");
    rdEn = 1'b1; regSel = 2'd1; #1; check("R6", {8'h00, rdData}, 16'h00AB); rdEn = 1'b0;

    // R1 / R7 / R9 / R11: random traffic checked against the model
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sel;
      logic [7:0] val;
      sel = 2'($urandom_range(0, 3));
      val = 8'($urandom());
      doWrite(sel, val);
      doRead(2'($urandom_range(0, 3)), "R7");
      doRead({~sel[1], 1'b1}, "R11");
      doLook(6'($urandom()), "R9");
      if (i % 50 == 0) begin
        regSel = sel; rdEn = 1'b0; #1;
        check("R8", {8'h00, rdData}, 16'h0000);
        doRead(sel, "R1");
      end
    end
    for (int e = 0; e < 64; e++) doLook(6'(e), "R9");
    finish();
  end
endmodule